// File: doc/BRIEF.md
# SWD host packet engine

This block performs the host side of a single Serial Wire Debug transaction. A caller presents an access-port/debug-port select, a read/write flag, a two-bit register address and, for writes, a 32-bit word, then pulses `start`. The engine produces the serial clock from the system clock and shifts out the 8-bit request. It releases the data line for a turnaround and collects the 3-bit acknowledge. It then reads or writes the data phase as the acknowledge allows, and ends with the trailing idle cycles that the packet type requires.

The bidirectional data wire is split into an output value, an output enable and an input. Completion is signalled by a one-cycle `done` pulse. The acknowledge, the read word and two error flags are then held until the next packet starts. Retries, port selection caching and multi-packet sequences belong to the caller.

Top module: `swd_host_packet`

## Requirements
- R1: After reset, `swclk` is 0, `busy` and `done` are 0, and the host drives the data line (`swdio_oe`=1) with `swdio_o`=0.
- R2: The request goes out LSB first as eight bits: 1, AP select, read flag, `addr[0]`, `addr[1]`, even parity (XOR of the four middle fields), 0, 1.
- R3: After the request, the host releases the line (`swdio_oe`=0) for one clock slot. It then samples three acknowledge bits LSB first, and reports them on `ack`. The valid codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100.
- R4: On a read with OK, 32 data bits (LSB first) and one parity bit are sampled and the word is returned on `rdata`. `par_err` is 1 exactly when the sampled parity bit differs from the XOR of the 32 bits.
- R5: A read with OK ends after one released turnaround slot following the parity bit, with no idle slots.
- R6: A read with a non-OK acknowledge is followed by one released turnaround slot, then eight slots in which the host drives 0. `rdata` reads 0.
- R7: A write with OK is followed by one released turnaround slot, then 32 host-driven data bits LSB first, an even parity bit, and two host-driven 0 slots.
- R8: A write with a non-OK acknowledge skips the data phase: one turnaround slot, then two host-driven 0 slots.
- R9: An acknowledge that is none of the three valid codes sets `proto_err`. The line is recovered exactly as for WAIT/FAULT of the same packet type.
- R10: Each clock slot lasts 2×`HALF_DIV` system cycles, low half first. `swclk` is low whenever no packet is active, and the host never changes `swdio_o` or `swdio_oe` while `swclk` is high.
- R11: `done` is a one-cycle pulse in the cycle `busy` falls. The results stay stable until the next start, and `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet (sampled while idle) |
| ap_sel | input | 1 | 1 selects an access port, 0 the debug port |
| rd_nwr | input | 1 | 1 read, 0 write |
| addr | input | 2 | Register address bits A2 (bit 0) and A3 (bit 1) |
| wdata | input | 32 | Write word |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 3 | Sampled acknowledge code |
| rdata | output | 32 | Read word |
| par_err | output | 1 | Read data parity mismatch |
| proto_err | output | 1 | Acknowledge was not a valid code |
| swclk | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Data value driven by the host |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_i | input | 1 | Data line as seen by the host |

## Verification
The reference model builds the expected slot sequence for each packet and checks the clock, drive enable and driven value on every system cycle. Reads are run with OK and both correct and corrupted parity, and with WAIT, FAULT and an undefined code. This separates the 46-slot, 21-slot and recovery paths and isolates the parity compare. Writes with OK, WAIT and an all-zero code split the 48-slot data path from the 15-slot skip path. Distinct port, direction and address fields in each packet expose any swap in request bit order or parity. A start pulse injected mid-packet must leave the waveform untouched.

// File: rtl/swd_host_packet.sv
module swd_host_packet #(
  parameter int HALF_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ap_sel,
  input  logic        rd_nwr,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  ack,
  output logic [31:0] rdata,
  output logic        par_err,
  output logic        proto_err,
  output logic        swclk,
  output logic        swdio_o,
  output logic        swdio_oe,
  input  logic        swdio_i
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_TRN1, S_ACK, S_RDAT, S_TRN2, S_WDAT, S_TAIL} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [5:0]    bitn, tail_last;
  logic          rd_q, rpar;
  logic [7:0]    req_q;
  logic [31:0]   wd_q;

  wire tick      = (cnt == '0);
  wire rise      = busy && tick && !swclk;
  wire fall      = busy && tick && swclk;
  wire ack_ok    = (ack == 3'b001);
  wire ack_valid = (ack == 3'b001) || (ack == 3'b010) || (ack == 3'b100);

  assign busy     = (st != S_IDLE);
  assign swdio_oe = (st == S_IDLE) || (st == S_REQ) || (st == S_WDAT) || (st == S_TAIL);

  always_comb begin
    case (st)
      S_REQ:   swdio_o = req_q[bitn[2:0]];
      S_WDAT:  swdio_o = bitn[5] ? ^wd_q : wd_q[bitn[4:0]];
      default: swdio_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= RELOAD; bitn <= '0; tail_last <= '0;
      rd_q <= 1'b0; rpar <= 1'b0; req_q <= '0; wd_q <= '0;
      done <= 1'b0; ack <= '0; rdata <= '0; par_err <= 1'b0; proto_err <= 1'b0;
      swclk <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= RELOAD;
        if (start) begin
          st <= S_REQ; bitn <= '0; rd_q <= rd_nwr; wd_q <= wdata;
          req_q <= {1'b1, 1'b0, ap_sel ^ rd_nwr ^ addr[0] ^ addr[1], addr[1], addr[0], rd_nwr, ap_sel, 1'b1};
          ack <= '0; rdata <= '0; par_err <= 1'b0; proto_err <= 1'b0;
        end
      end else begin
        cnt <= tick ? RELOAD : cnt - 1'b1;
        if (rise) begin
          swclk <= 1'b1;
          if (st == S_ACK) ack[bitn[1:0]] <= swdio_i;
          if (st == S_RDAT) begin
            if (bitn[5]) rpar <= swdio_i;
            else         rdata[bitn[4:0]] <= swdio_i;
          end
        end
        if (fall) begin
          swclk <= 1'b0;
          bitn  <= bitn + 1'b1;
          case (st)
            S_REQ:  if (bitn == 6'd7) begin st <= S_TRN1; bitn <= '0; end
            S_TRN1: begin st <= S_ACK; bitn <= '0; end
            S_ACK:  if (bitn == 6'd2) begin
                      proto_err <= !ack_valid;
                      st   <= (rd_q && ack_ok) ? S_RDAT : S_TRN2;
                      bitn <= '0;
                    end
            S_RDAT: if (bitn == 6'd32) begin
                      par_err <= (^rdata) ^ rpar;
                      st <= S_TRN2; bitn <= '0;
                    end
            S_TRN2: begin
                      bitn <= '0;
                      if (rd_q && ack_ok)  begin st <= S_IDLE; done <= 1'b1; end
                      else if (rd_q)       begin st <= S_TAIL; tail_last <= 6'd7; end
                      else if (ack_ok)     st <= S_WDAT;
                      else                 begin st <= S_TAIL; tail_last <= 6'd1; end
                    end
            S_WDAT: if (bitn == 6'd32) begin st <= S_TAIL; tail_last <= 6'd1; bitn <= '0; end
            S_TAIL: if (bitn == tail_last) begin st <= S_IDLE; done <= 1'b1; bitn <= '0; end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !swclk); // R10
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe))); // R10
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (swdio_oe && swdio_o)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
  AST_PERR_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && par_err) |-> (rd_q && ack == 3'b001)); // R4
  AST_PROTO_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && proto_err) |-> (ack != 3'b001)); // R9
endmodule

// File: tb/swd_host_packet_bench.sv
`timescale 1ns/1ps
module swd_host_packet_bench;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ap_sel = 1'b0, rd_nwr = 1'b0, swdio_i = 1'b1;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic busy, done, par_err, proto_err, swclk, swdio_o, swdio_oe;
  logic [2:0] ack;
  logic [31:0] rdata;

  always #4 clk = ~clk;

  swd_host_packet #(.HALF_DIV(H)) u_swd_host_packet (
    .clk(clk), .rst_n(rst_n), .start(start), .ap_sel(ap_sel), .rd_nwr(rd_nwr),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .ack(ack), .rdata(rdata),
    .par_err(par_err), .proto_err(proto_err), .swclk(swclk), .swdio_o(swdio_o),
    .swdio_oe(swdio_oe), .swdio_i(swdio_i));

  typedef struct {
    logic  oe, o, tdrv, tval;
    string tag;
  } slot_t;

  slot_t q[$];
  int vectors = 0, miss = 0, cyc = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miss++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  function automatic slot_t mk(input logic oe, input logic o, input logic tdrv, input logic tval, input string tag);
    slot_t s;
    s.oe = oe; s.o = o; s.tdrv = tdrv; s.tval = tval; s.tag = tag;
    return s;
  endfunction

  task automatic run_pkt(input logic ap, input logic rd, input logic [1:0] a, input logic [31:0] wd,
                         input logic [2:0] ackv, input logic [31:0] rdv, input logic badp, input logic poke);
    logic p, ok, valid;
    logic [7:0] req;
    int n;
    slot_t s;
    p = ap ^ rd ^ a[0] ^ a[1];
    req = {1'b1, 1'b0, p, a[1], a[0], rd, ap, 1'b1};
    ok = (ackv == 3'b001);
    valid = ok || ackv == 3'b010 || ackv == 3'b100;
    q.delete();
    for (int i = 0; i < 8; i++) q.push_back(mk(1'b1, req[i], 1'b0, 1'b0, "R2"));
    q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, "R3"));
    for (int i = 0; i < 3; i++) q.push_back(mk(1'b0, 1'b0, 1'b1, ackv[i], "R3"));
    if (rd && ok) begin
      for (int i = 0; i < 32; i++) q.push_back(mk(1'b0, 1'b0, 1'b1, rdv[i], "R4"));
      q.push_back(mk(1'b0, 1'b0, 1'b1, (^rdv) ^ badp, "R4"));
      q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, "R5"));
    end else if (rd) begin
      q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, valid ? "R6" : "R9"));
      for (int i = 0; i < 8; i++) q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, valid ? "R6" : "R9"));
    end else begin
      q.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, ok ? "R7" : "R8"));
      if (ok) begin
        for (int i = 0; i < 32; i++) q.push_back(mk(1'b1, wd[i], 1'b0, 1'b0, "R7"));
        q.push_back(mk(1'b1, ^wd, 1'b0, 1'b0, "R7"));
      end
      for (int i = 0; i < 2; i++) q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, ok ? "R7" : (valid ? "R8" : "R9")));
    end
    n = q.size();

    @(negedge clk);
    ap_sel = ap; rd_nwr = rd; addr = a; wdata = wd; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 2 * H * n; t++) begin
      s = q[t / (2 * H)];
      chk("R10", "swclk", 32'(swclk), 32'((t % (2 * H)) >= H));
      chk(s.tag, "oe", 32'(swdio_oe), 32'(s.oe));
      if (s.oe) chk(s.tag, "o", 32'(swdio_o), 32'(s.o));
      chk("R11", "busy", 32'(busy), 32'd1);
      chk("R11", "done", 32'(done), 32'd0);
      swdio_i = s.tdrv ? s.tval : 1'b1;
      if (poke && t == 10) begin
        ap_sel = ~ap; rd_nwr = ~rd; addr = ~a; wdata = ~wd; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    swdio_i = 1'b1;
    chk("R11", "done", 32'(done), 32'd1);
    chk("R11", "busy", 32'(busy), 32'd0);
    chk("R10", "swclk", 32'(swclk), 32'd0);
    chk("R3", "ack", 32'(ack), 32'(ackv));
    chk(rd ? (ok ? "R4" : "R6") : "R7", "rdata", rdata, (rd && ok) ? rdv : 32'd0);
    chk("R4", "par_err", 32'(par_err), 32'(rd && ok && badp));
    chk("R9", "proto_err", 32'(proto_err), 32'(!valid));
    @(negedge clk);
    chk("R11", "done_after", 32'(done), 32'd0);
    chk("R11", "ack_held", 32'(ack), 32'(ackv));
    chk("R1", "idle_oe", 32'(swdio_oe), 32'd1);
    chk("R1", "idle_o", 32'(swdio_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "swclk", 32'(swclk), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "oe", 32'(swdio_oe), 32'd1);
    chk("R1", "o", 32'(swdio_o), 32'd0);

    run_pkt(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h2BA0_1477, 1'b0, 1'b0);
    run_pkt(1'b1, 1'b1, 2'b11, 32'h0, 3'b001, 32'h8000_0001, 1'b1, 1'b1);
    run_pkt(1'b1, 1'b1, 2'b01, 32'h0, 3'b010, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run_pkt(1'b0, 1'b1, 2'b10, 32'h0, 3'b100, 32'h1234_5678, 1'b0, 1'b0);
    run_pkt(1'b0, 1'b1, 2'b01, 32'h0, 3'b111, 32'h0, 1'b0, 1'b0);
    run_pkt(1'b1, 1'b0, 2'b10, 32'hA05F_0003, 3'b001, 32'h0, 1'b0, 1'b1);
    run_pkt(1'b0, 1'b0, 2'b01, 32'h5000_0000, 3'b010, 32'h0, 1'b0, 1'b0);
    run_pkt(1'b1, 1'b0, 2'b00, 32'h2300_0052, 3'b000, 32'h0, 1'b0, 1'b0);
    run_pkt(1'b0, 1'b0, 2'b11, 32'h0000_0001, 3'b001, 32'h0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule